// File: doc/BRIEF.md
# Integer Execution Unit with Overflow Trap

This unit is the integer datapath of a 32-bit load/store core. Each operation it accepts has two operands, a 4-bit operation code and a 5-bit immediate shift amount. It produces a result word, a trap request for signed overflow and a write-enable for the destination register. It handles add and subtract in two forms: one traps on signed overflow and one wraps. It also handles left, logical-right and arithmetic-right shifts by an immediate or a register amount, right rotate in both amount forms, and counting of leading zeros or leading ones.

Operations arrive on a valid/ready stream and results leave on another. With `REG_OUT=1`, the default, a single register stage sits between the two streams. The input is ready whenever that stage is empty or its content is being taken in the same cycle. An accepted operation shows up at the output on the next clock edge. While `out_ready` is low, a waiting result stays on the output unchanged. With `REG_OUT=0` the unit is purely combinational: valid and ready pass straight through.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 0, trapping add, returns a+b modulo 2^32. It raises `out_ovf` exactly when a and b have equal sign bits and the sum's sign bit differs from them.
- R2: Opcode 2, trapping subtract, returns a-b modulo 2^32. It raises `out_ovf` exactly when a and b differ in sign and the difference's sign bit differs from a's.
- R3: Opcodes 1 and 3, wrapping add and subtract, return a+b and a-b modulo 2^32 and never raise `out_ovf`.
- R4: Opcodes 4 (shift left) and 5 (logical shift right) shift b by `in_shamt`. Vacated bits are filled with zeros, and a has no effect on the result.
- R5: Opcodes 6 and 10, arithmetic shift right, fill the vacated upper bits with b's bit 31.
- R6: Opcodes 8 to 11 are the register-amount forms of opcodes 4 to 7. They shift b by a[4:0] only, ignoring a[31:5] and `in_shamt`.
- R7: Opcodes 7 and 11 rotate b right by n, giving (b >> n) | (b << (32-n)). A rotate by 0 returns b unchanged.
- R8: Opcode 12 returns the number of leading zero bits of a, which is 32 for a zero input. Opcode 13 returns the number of leading one bits of a, which is 32 for an all-ones input.
- R9: `out_wen` is the inverse of `out_ovf` for every result.
- R10: Opcodes 14 and 15 return a zero result with `out_ovf` low.
- R11: `in_ready` is high when the output stage is empty or `out_ready` is high. An accepted operation appears on the output one cycle later. A result held while `out_ready` is low keeps `out_valid` high and its value stable.
- R12: While `rst_n` is low and right after it is released, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | First operand; register shift amount in bits 4:0 |
| in_b | input | 32 | Second operand; value shifted or rotated |
| in_shamt | input | 5 | Immediate shift amount |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 32 | Result word |
| out_ovf | output | 1 | Signed-overflow trap request |
| out_wen | output | 1 | Destination write enable |

## Verification
The handshake assertions assume the consumer only lowers `out_ready` between clock edges. They also assume operand and opcode values are fixed before the edge on which the transfer happens. The bench changes its inputs 1 ns after a rising edge and samples at the falling edge, which keeps all stimulus inside that window. The datapath assertions assume the opcode is one of the sixteen 4-bit codes. Every code, including the two unused ones, is driven on purpose, and operands are chosen to reach both signed overflow boundaries and every shift amount. Back-pressure is applied at random in a separate phase so that held results get exercised.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  typedef enum logic [3:0] {
    OP_ADD_T = 4'd0,
    OP_ADD_W = 4'd1,
    OP_SUB_T = 4'd2,
    OP_SUB_W = 4'd3,
    OP_SHL_I = 4'd4,
    OP_SHR_I = 4'd5,
    OP_SAR_I = 4'd6,
    OP_ROR_I = 4'd7,
    OP_SHL_V = 4'd8,
    OP_SHR_V = 4'd9,
    OP_SAR_V = 4'd10,
    OP_ROR_V = 4'd11,
    OP_LZ    = 4'd12,
    OP_LO    = 4'd13
  } iexu_op_e;

  // low two opcode bits of the shift group select the kind directly
  typedef enum logic [1:0] {
    SH_LEFT   = 2'd0,
    SH_LRIGHT = 2'd1,
    SH_ARIGHT = 2'd2,
    SH_ROTR   = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/iexu_addsub.sv
module iexu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         trap,
  output logic [W-1:0] sum,
  output logic         ovf
);
  logic [W-1:0] sign_err;

  always_comb begin
    sum      = sub ? (a - b) : (a + b);
    sign_err = sub ? ((a ^ b) & (a ^ sum)) : (~(a ^ b) & (sum ^ b));
    ovf      = trap & sign_err[W-1];
  end

  always_comb begin
    if (ovf && !sub)
      a_r1_add_ovf_sign: assert (a[W-1] == b[W-1] && sum[W-1] != a[W-1]);
    if (ovf && sub)
      a_r2_sub_ovf_sign: assert (a[W-1] != b[W-1] && sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/iexu_shift.sv
module iexu_shift
  import iexu_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  shift_kind_e   kind,
  output logic [W-1:0]  res
);
  localparam int BW = SW + 1;
  logic [BW-1:0] back;

  always_comb begin
    back = BW'(W) - BW'(amt);
    unique case (kind)
      SH_LEFT:   res = val << amt;
      SH_LRIGHT: res = val >> amt;
      SH_ARIGHT: res = W'($signed(val) >>> amt);
      default:   res = (amt == '0) ? val : ((val >> amt) | (val << back));
    endcase
  end

  always_comb begin
    if (kind == SH_ARIGHT)
      a_r5_sign_fill: assert (res[W-1] == val[W-1]);
    if (kind == SH_LRIGHT && amt != '0)
      a_r4_zero_fill: assert (res[W-1] == 1'b0);
  end
endmodule

// File: rtl/iexu_lead.sv
module iexu_lead #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val,
  input  logic          ones,
  output logic [CW-1:0] cnt
);
  logic [W-1:0] probe;
  logic         found;

  always_comb begin
    probe = ones ? ~val : val;
    cnt   = CW'(W);
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && probe[i]) begin
        cnt   = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (cnt == CW'(W))
      a_r8_full_count: assert (ones ? (&val) : (~|val));
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int W       = 32,
  parameter int REG_OUT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [3:0]           in_op,
  input  logic [W-1:0]         in_a,
  input  logic [W-1:0]         in_b,
  input  logic [$clog2(W)-1:0] in_shamt,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_res,
  output logic                 out_ovf,
  output logic                 out_wen
);
  localparam int SW = $clog2(W);
  localparam int CW = SW + 1;

  iexu_op_e      op;
  logic          is_sub, is_trap, is_var;
  logic [SW-1:0] sh_amt;
  shift_kind_e   sh_kind;
  logic [W-1:0]  as_sum, sh_res;
  logic          as_ovf;
  logic [CW-1:0] lead_cnt;
  logic [W-1:0]  c_res;
  logic          c_ovf;

  always_comb begin
    op      = iexu_op_e'(in_op);
    is_sub  = (op == OP_SUB_T) || (op == OP_SUB_W);
    is_trap = (op == OP_ADD_T) || (op == OP_SUB_T);
    is_var  = in_op[3];
    sh_amt  = is_var ? in_a[SW-1:0] : in_shamt;
    sh_kind = shift_kind_e'(in_op[1:0]);
  end

  iexu_addsub #(.W(W)) u_addsub (
    .a(in_a), .b(in_b), .sub(is_sub), .trap(is_trap), .sum(as_sum), .ovf(as_ovf)
  );

  iexu_shift #(.W(W), .SW(SW)) u_shift (
    .val(in_b), .amt(sh_amt), .kind(sh_kind), .res(sh_res)
  );

  iexu_lead #(.W(W), .CW(CW)) u_lead (
    .val(in_a), .ones(op == OP_LO), .cnt(lead_cnt)
  );

  always_comb begin
    c_res = '0;
    c_ovf = 1'b0;
    case (op)
      OP_ADD_T, OP_ADD_W, OP_SUB_T, OP_SUB_W: begin
        c_res = as_sum;
        c_ovf = as_ovf;
      end
      OP_SHL_I, OP_SHR_I, OP_SAR_I, OP_ROR_I,
      OP_SHL_V, OP_SHR_V, OP_SAR_V, OP_ROR_V: c_res = sh_res;
      OP_LZ, OP_LO: c_res = W'(lead_cnt);
      default: ;
    endcase
  end

  generate
    if (REG_OUT != 0) begin : g_reg
      logic         vld_q;
      logic [W-1:0] res_q;
      logic         ovf_q;
      logic [W-1:0] chk_sum;

      assign chk_sum   = in_a + in_b;
      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_res   = res_q;
      assign out_ovf   = ovf_q;
      assign out_wen   = !ovf_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
          ovf_q <= 1'b0;
        end else if (in_valid && in_ready) begin
          vld_q <= 1'b1;
          res_q <= c_res;
          ovf_q <= c_ovf;
        end else if (out_ready) begin
          vld_q <= 1'b0;
        end
      end

      a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_ovf));

      a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (in_op >= 4'd14) |=> out_valid && out_res == '0 && !out_ovf);

      a_r1_trap_taken: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_op == 4'd0 && in_a[W-1] == in_b[W-1]
        && chk_sum[W-1] != in_a[W-1] |=> out_ovf && !out_wen);

      a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (in_op == 4'd1 || in_op == 4'd3) |=> !out_ovf);
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_res   = c_res;
      assign out_ovf   = c_ovf;
      assign out_wen   = !c_ovf;
    end
  endgenerate
endmodule

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [4:0]  in_shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_res;
  logic        out_ovf, out_wen;

  always #2 clk = ~clk;

  int_exec_unit #(.W(W), .REG_OUT(1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_ovf(out_ovf), .out_wen(out_wen)
  );

  typedef struct { logic [3:0] op; logic [31:0] res; logic ovf; } exp_t;
  exp_t sbq[$];
  int   checks = 0, fails = 0;
  logic stall_mode = 1'b0;
  logic summary_done = 1'b0;

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd2: return "R2";
      4'd1, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd10: return "R5";
      4'd8, 4'd9: return "R6";
      4'd7, 4'd11: return "R7";
      4'd12, 4'd13: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic exp_t model(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
    exp_t e;
    logic [32:0] wide;
    logic [63:0] dbl;
    int n;
    int amt;
    e.op = op; e.res = '0; e.ovf = 1'b0;
    amt = (op >= 4'd8 && op <= 4'd11) ? int'(a[4:0]) : int'(sh);
    case (op)
      4'd0, 4'd1: begin
        wide = {a[31], a} + {b[31], b};
        e.res = wide[31:0];
        e.ovf = (op == 4'd0) && (wide[32] != wide[31]);
      end
      4'd2, 4'd3: begin
        wide = {a[31], a} - {b[31], b};
        e.res = wide[31:0];
        e.ovf = (op == 4'd2) && (wide[32] != wide[31]);
      end
      4'd4, 4'd8: e.res = b << amt;
      4'd5, 4'd9: e.res = b >> amt;
      4'd6, 4'd10: begin
        e.res = b >> amt;
        for (int k = 0; k < amt; k++) e.res[31-k] = b[31];
      end
      4'd7, 4'd11: begin
        dbl = {b, b} >> amt;
        e.res = dbl[31:0];
      end
      4'd12, 4'd13: begin
        n = 0;
        for (int k = 31; k >= 0; k--) begin
          if (a[k] != (op == 4'd13)) break;
          n++;
        end
        e.res = 32'(n);
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic send(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
    @(posedge clk);
    #1;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_shamt = sh;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    sbq.push_back(model(op, a, b, sh));
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  logic        held = 1'b0;
  logic [31:0] held_res;
  logic        held_ovf;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        chk(out_valid === 1'b1, "R11", "held valid", 32'(out_valid), 32'd1);
        chk(out_res === held_res && out_ovf === held_ovf, "R11", "held value",
            out_res, held_res);
      end
      held = out_valid && !out_ready;
      held_res = out_res;
      held_ovf = out_ovf;
      if (out_valid && out_ready) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R11", "unexpected output", out_res, 32'd0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(out_res === e.res, tag_of(e.op), $sformatf("result op=%0d", e.op), out_res, e.res);
          chk(out_ovf === e.ovf, (e.op == 4'd2) ? "R2" : (e.op == 4'd0 ? "R1" : "R3"),
              $sformatf("ovf op=%0d", e.op), 32'(out_ovf), 32'(e.ovf));
          chk(out_wen === !e.ovf, "R9", "wen", 32'(out_wen), 32'(!e.ovf));
        end
      end
    end
  end

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R12", "valid in reset", 32'(out_valid), 32'd0);
    chk(in_ready === 1'b1, "R12", "ready in reset", 32'(in_ready), 32'd1);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R12", "valid after reset", 32'(out_valid), 32'd0);

    // R1 / R2 / R3 overflow boundaries
    send(4'd0, 32'h7fffffff, 32'h00000001, 0);
    send(4'd0, 32'h80000000, 32'hffffffff, 0);
    send(4'd0, 32'h7ffffffe, 32'h00000001, 0);
    send(4'd0, 32'h80000000, 32'h7fffffff, 0);
    send(4'd0, 32'hffffffff, 32'hffffffff, 0);
    send(4'd2, 32'h80000000, 32'h00000001, 0);
    send(4'd2, 32'h7fffffff, 32'hffffffff, 0);
    send(4'd2, 32'h00000000, 32'h80000000, 0);
    send(4'd2, 32'hffffffff, 32'h80000000, 0);
    send(4'd2, 32'h80000001, 32'h00000001, 0);
    send(4'd1, 32'h7fffffff, 32'h00000001, 0);
    send(4'd3, 32'h80000000, 32'h00000001, 0);
    send(4'd1, 32'hffffffff, 32'h00000001, 0);

    // every shift amount, immediate and register forms (R4..R7)
    for (int s = 0; s < 32; s++) begin
      for (int op = 4; op < 12; op++) begin
        v = (s[0]) ? 32'h8421_f00d : 32'h5a3c_96e1;
        if (op >= 8) send(4'(op), 32'hffffffe0 | 32'(s), v, 5'(31 - s));
        else         send(4'(op), $urandom, v, 5'(s));
      end
    end

    // leading zeros / ones (R8)
    send(4'd12, 32'h0, 32'h0, 0);
    send(4'd13, 32'hffffffff, 32'h0, 0);
    for (int k = 0; k < 32; k++) begin
      send(4'd12, 32'h1 << k, 32'h0, 0);
      send(4'd13, ~(32'h1 << k), 32'h0, 0);
    end

    // unused codes (R10)
    send(4'd14, 32'h12345678, 32'h9abcdef0, 5'd3);
    send(4'd15, 32'hffffffff, 32'hffffffff, 5'd31);

    // random mix with back-pressure (R11)
    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++)
      send(4'($urandom % 16), $urandom, $urandom, 5'($urandom));

    @(posedge clk); #1 in_valid = 1'b0;
    stall_mode = 1'b0;
    for (int i = 0; i < 200 && sbq.size() > 0; i++) @(negedge clk);
    chk(sbq.size() == 0, "R11", "drain", 32'(sbq.size()), 32'd0);
    summary();
    $finish;
  end
endmodule